// File: doc/BRIEF.md
# Shared-Pin Bit-Clock / De-Emphasis Mode Detector

This block watches one input pin that a board may use in either of two ways. It may carry a running serial bit clock, or it may be tied to a static level that turns a de-emphasis filter on or off. The block decides which use applies by counting rising edges on the pin inside each half-period (phase) of the frame clock. When the pin carries a clock, the block raises an external-clock flag and marks every synchronised rising edge with a one-cycle strobe. The serial receiver uses that strobe as its bit clock. When the pin is static, the block takes a vote on the pin level at successive falling edges of the frame clock and produces a de-emphasis enable from that vote.

Both the pin and the frame clock are asynchronous to the master clock. Each passes through a flop synchroniser of configurable depth. All decisions use the synchronised copies. Hysteresis works in both directions. Entry to external mode needs a burst of rising edges within one phase. Exit needs whole frames with no rising edge at all. A change of the de-emphasis state needs a run of identical level samples. A frame runs from one falling edge of the frame clock to the next.

Top module: `shared_pin_mode_det`

## Requirements
- R1: During and after reset the external-clock flag is 0, the de-emphasis enable is 0 and the rising-edge strobe is 0.
- R2: Each rising edge of the synchronised pin produces exactly one strobe on `pin_rise_o`, one cycle wide. No other cycle produces a strobe.
- R3: In internal mode, the flag goes to 1 on the 16th (EDGE_COUNT) rising edge of the pin seen inside one phase of the frame clock. Fifteen rising edges in a phase leave it at 0.
- R4: The rising-edge count restarts at every transition of the frame clock, whether rising or falling. Edges split across two phases do not add up, even when the total exceeds 16.
- R5: In external mode, the flag returns to 0 at the second (QUIET_FRAMES) consecutive frame-clock falling edge that closes a frame with no rising edge on the pin. A frame containing any rising edge resets that count.
- R6: In internal mode, the pin level is sampled at each falling edge of the frame clock. Five (VOTE_COUNT) consecutive samples at level 0 set the de-emphasis enable to 1.
- R7: In internal mode, five consecutive samples at level 1 set the de-emphasis enable to 0.
- R8: A sample that differs from the previous one restarts the run at length 1. The enable keeps its value until a run reaches five.
- R9: While the flag is 1, the de-emphasis enable is 0 and the vote history is discarded. After a return to internal mode, five new samples are needed before the enable can become 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shared_pin_i | input | 1 | Shared pin: bit clock or de-emphasis level (asynchronous) |
| lrck_i | input | 1 | Frame clock, one phase per channel (asynchronous) |
| ext_mode_o | output | 1 | 1 = pin carries an external bit clock |
| deemph_en_o | output | 1 | De-emphasis filter enable |
| pin_rise_o | output | 1 | One-cycle strobe per synchronised rising edge of the pin |

## Verification
The hardest condition to reach from the ports is a return to internal mode that arrives partway through a level vote. Reaching it needs a full edge burst inside one phase, then frames that contain a few edges, then exactly two silent frames, and then the vote history must be seen to restart. The stimulus builds each frame-clock phase from an edge count and a final pin level. Directed sequences walk through this chain and the 15/16-edge and split-phase boundaries. Seeded random phases, weighted toward edge counts of 15, 16 and 20 and toward repeated end levels, then cross mode changes with partial votes many times. A phase-level model in the bench predicts every outcome.

// File: rtl/smd_pkg.sv
package smd_pkg;

   // Which transition of a synchronised signal an edge detector reports.
   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2
   } edge_kind_e;

   // Counter width able to hold values 0..max_val.
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/smd_sync.sv
module smd_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("smd_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("smd_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= '0;
            else         chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= '0;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/smd_edge.sv
module smd_edge
   import smd_pkg::*;
#(
   parameter edge_kind_e KIND = EDGE_RISE
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sig_i,
   output logic pulse_o
);

   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sig_i;
   end

   if (KIND == EDGE_RISE) begin : g_rise
      assign pulse_o = sig_i & ~prev_q;
   end else if (KIND == EDGE_FALL) begin : g_fall
      assign pulse_o = ~sig_i & prev_q;
   end else begin : g_both
      assign pulse_o = sig_i ^ prev_q;
   end

   // R2: a detected transition can never repeat on the next cycle for single-direction kinds
   if (KIND != EDGE_BOTH) begin : g_chk
      a_r2_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pulse_o |=> !pulse_o);
   end

endmodule

// File: rtl/smd_mode_ctl.sv
module smd_mode_ctl
   import smd_pkg::*;
#(
   parameter int unsigned EDGE_COUNT   = 16,
   parameter int unsigned QUIET_FRAMES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_rise_i,
   input  logic lr_toggle_i,
   input  logic lr_fall_i,
   output logic ext_mode_o
);

   localparam int unsigned CW = cnt_width(EDGE_COUNT);
   localparam int unsigned QW = cnt_width(QUIET_FRAMES);
   localparam logic [CW-1:0] EDGE_MAX  = CW'(EDGE_COUNT);
   localparam logic [CW-1:0] EDGE_LAST = CW'(EDGE_COUNT - 1);
   localparam logic [QW-1:0] QUIET_LAST = QW'(QUIET_FRAMES - 1);

   if (EDGE_COUNT < 2) begin : g_bad_edges
      $error("smd_mode_ctl: EDGE_COUNT must be at least 2");
   end
   if (QUIET_FRAMES < 1) begin : g_bad_quiet
      $error("smd_mode_ctl: QUIET_FRAMES must be at least 1");
   end

   logic [CW-1:0] edge_cnt_q;
   logic [QW-1:0] quiet_cnt_q;
   logic          seen_q;
   logic          ext_q;
   logic          burst_hit;

   // Rising edges inside the current phase; restarted at each frame-clock transition.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         edge_cnt_q <= '0;
      end else if (lr_toggle_i) begin
         edge_cnt_q <= pin_rise_i ? CW'(1) : '0;
      end else if (pin_rise_i && (edge_cnt_q != EDGE_MAX)) begin
         edge_cnt_q <= edge_cnt_q + CW'(1);
      end
   end

   assign burst_hit = pin_rise_i && !lr_toggle_i && (edge_cnt_q == EDGE_LAST);

   // Any rising edge since the last frame boundary.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_q <= 1'b0;
      end else if (lr_fall_i) begin
         seen_q <= pin_rise_i;
      end else if (pin_rise_i) begin
         seen_q <= 1'b1;
      end
   end

   // Mode state with frame-count hysteresis on the way out.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ext_q       <= 1'b0;
         quiet_cnt_q <= '0;
      end else if (!ext_q) begin
         if (burst_hit) begin
            ext_q       <= 1'b1;
            quiet_cnt_q <= '0;
         end
      end else if (lr_fall_i) begin
         if (seen_q) begin
            quiet_cnt_q <= '0;
         end else if (quiet_cnt_q == QUIET_LAST) begin
            ext_q       <= 1'b0;
            quiet_cnt_q <= '0;
         end else begin
            quiet_cnt_q <= quiet_cnt_q + QW'(1);
         end
      end
   end

   assign ext_mode_o = ext_q;

   a_r3_entry_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ext_q) |-> $past(pin_rise_i));

   a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_cnt_q <= EDGE_MAX);

   a_r5_exit_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ext_q) |-> ($past(lr_fall_i) && !$past(seen_q)));

   a_r5_quiet_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      quiet_cnt_q <= QUIET_LAST);

endmodule

// File: rtl/smd_level_vote.sv
module smd_level_vote
   import smd_pkg::*;
#(
   parameter int unsigned VOTE_COUNT = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic enable_i,
   input  logic sample_i,
   input  logic level_i,
   output logic active_o
);

   localparam int unsigned RW = cnt_width(VOTE_COUNT);
   localparam logic [RW-1:0] RUN_MAX = RW'(VOTE_COUNT);

   if (VOTE_COUNT < 1) begin : g_bad_vote
      $error("smd_level_vote: VOTE_COUNT must be at least 1");
   end

   logic [RW-1:0] run_q;
   logic [RW-1:0] run_next;
   logic          last_q;
   logic          state_q;

   always_comb begin
      if ((run_q == '0) || (level_i != last_q)) begin
         run_next = RW'(1);
      end else if (run_q != RUN_MAX) begin
         run_next = run_q + RW'(1);
      end else begin
         run_next = run_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= '0;
         last_q  <= 1'b0;
         state_q <= 1'b0;
      end else if (!enable_i) begin
         run_q   <= '0;
         last_q  <= 1'b0;
         state_q <= 1'b0;
      end else if (sample_i) begin
         run_q  <= run_next;
         last_q <= level_i;
         if (run_next == RUN_MAX) begin
            state_q <= ~level_i;
         end
      end
   end

   assign active_o = state_q;

   a_r8_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= RUN_MAX);

   a_r8_change_needs_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(state_q) && $past(enable_i)) |-> $past(sample_i));

endmodule

// File: rtl/shared_pin_mode_det.sv
module shared_pin_mode_det
   import smd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned EDGE_COUNT   = 16,
   parameter int unsigned QUIET_FRAMES = 2,
   parameter int unsigned VOTE_COUNT   = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic shared_pin_i,
   input  logic lrck_i,
   output logic ext_mode_o,
   output logic deemph_en_o,
   output logic pin_rise_o
);

   localparam int unsigned IDX_PIN = 0;
   localparam int unsigned IDX_LR  = 1;

   logic [1:0] sync_q;
   logic       pin_s;
   logic       lr_s;
   logic       pin_rise;
   logic       lr_fall;
   logic       lr_toggle;
   logic       ext_mode;
   logic       vote_state;

   smd_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({lrck_i, shared_pin_i}),
      .q_o    (sync_q)
   );

   assign pin_s = sync_q[IDX_PIN];
   assign lr_s  = sync_q[IDX_LR];

   smd_edge #(.KIND(EDGE_RISE)) u_pin_rise (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sig_i   (pin_s),
      .pulse_o (pin_rise)
   );

   smd_edge #(.KIND(EDGE_FALL)) u_lr_fall (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sig_i   (lr_s),
      .pulse_o (lr_fall)
   );

   smd_edge #(.KIND(EDGE_BOTH)) u_lr_toggle (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sig_i   (lr_s),
      .pulse_o (lr_toggle)
   );

   smd_mode_ctl #(
      .EDGE_COUNT   (EDGE_COUNT),
      .QUIET_FRAMES (QUIET_FRAMES)
   ) u_mode (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_rise_i  (pin_rise),
      .lr_toggle_i (lr_toggle),
      .lr_fall_i   (lr_fall),
      .ext_mode_o  (ext_mode)
   );

   smd_level_vote #(
      .VOTE_COUNT (VOTE_COUNT)
   ) u_vote (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .enable_i (~ext_mode),
      .sample_i (lr_fall),
      .level_i  (pin_s),
      .active_o (vote_state)
   );

   assign ext_mode_o  = ext_mode;
   assign deemph_en_o = vote_state & ~ext_mode;
   assign pin_rise_o  = pin_rise;

   // R1: reset holds every output inactive
   a_r1_reset_idle: assert property (@(posedge clk_i)
      !rst_ni |=> (!ext_mode_o && !deemph_en_o && !pin_rise_o));

   // R2: strobes are isolated cycles
   a_r2_strobe_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_rise_o |=> !pin_rise_o);

   // R6: enable only rises after a low sample at a frame boundary
   a_r6_on_low_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(deemph_en_o) |-> ($past(lr_fall) && !$past(pin_s)));

   // R7: enable only drops in internal mode after a high sample
   a_r7_off_high_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(deemph_en_o) && !ext_mode_o) |-> ($past(lr_fall) && $past(pin_s)));

   // R9: the vote history is gone once external mode has lasted a cycle
   a_r9_history_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_mode_o && $past(ext_mode_o)) |-> !vote_state);

endmodule

// File: tb/shared_pin_mode_det_tb_top.sv
`timescale 1ns/1ps
module shared_pin_mode_det_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin = 1'b0;
   logic lrck = 1'b0;
   logic ext_mode, deemph_en, pin_rise;

   int n_chk  = 0;
   int n_fail = 0;
   int rise_seen = 0;
   bit done = 1'b0;

   // bench model state
   bit m_ext = 1'b0;
   int m_quiet = 0;
   int m_since_fall = 0;
   int m_run = 0;
   bit m_last = 1'b0;
   bit m_state = 1'b0;
   bit m_lr = 1'b0;
   bit m_pin_end = 1'b0;

   localparam int EDGES = 16;
   localparam int QUIET = 2;
   localparam int VOTES = 5;

   always #2 clk = ~clk;

   shared_pin_mode_det dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .shared_pin_i (pin),
      .lrck_i       (lrck),
      .ext_mode_o   (ext_mode),
      .deemph_en_o  (deemph_en),
      .pin_rise_o   (pin_rise)
   );

   always @(negedge clk) if (rst_n && pin_rise) rise_seen++;

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // model of one frame boundary (frame clock falling edge)
   function automatic void model_fall();
      bit old_ext = m_ext;
      if (m_ext) begin
         if (m_since_fall == 0) m_quiet++;
         else m_quiet = 0;
         if (m_quiet == QUIET) begin
            m_ext = 1'b0;
            m_quiet = 0;
         end
      end
      m_since_fall = 0;
      if (old_ext) begin
         m_run = 0; m_last = 1'b0; m_state = 1'b0;
      end else begin
         if (m_run == 0 || m_pin_end != m_last) m_run = 1;
         else if (m_run < VOTES) m_run++;
         m_last = m_pin_end;
         if (m_run == VOTES) m_state = !m_pin_end;
      end
   endfunction

   function automatic void model_phase(input int rises);
      m_since_fall += rises;
      if (!m_ext && rises >= EDGES) begin
         m_ext = 1'b1;
         m_quiet = 0;
         m_run = 0; m_last = 1'b0; m_state = 1'b0;
      end
   endfunction

   // One frame-clock phase: set level, pin low, n pulses, final pin level.
   task automatic phase(input bit lr, input int n, input bit endl, input string tag);
      int rises;
      rise_seen = 0;
      if (m_lr && !lr) model_fall();
      m_lr = lr;
      lrck = lr;
      wait_cyc(6);
      pin = 1'b0;
      wait_cyc(3);
      for (int i = 0; i < n; i++) begin
         pin = 1'b1; wait_cyc(3);
         pin = 1'b0; wait_cyc(3);
      end
      pin = endl;
      wait_cyc(6);
      rises = n + (endl ? 1 : 0);
      m_pin_end = endl;
      model_phase(rises);
      chk({"R2 strobe count ", tag}, rise_seen, rises);
      chk({"R3 R4 R5 external flag ", tag}, int'(ext_mode), int'(m_ext));
      chk({"R6 R7 R8 R9 de-emphasis ", tag}, int'(deemph_en), int'(m_state && !m_ext));
   endtask

   // a frame: high phase then low phase; the sample is the high phase end level
   task automatic frame(input int n_hi, input bit end_hi, input int n_lo, input bit end_lo,
                        input string tag);
      phase(1'b1, n_hi, end_hi, tag);
      phase(1'b0, n_lo, end_lo, tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd4711));
      wait_cyc(5);
      chk("R1 flag in reset", int'(ext_mode), 0);
      chk("R1 de-emphasis in reset", int'(deemph_en), 0);
      chk("R1 strobe in reset", int'(pin_rise), 0);
      rst_n = 1'b1;
      wait_cyc(4);
      chk("R1 flag after reset", int'(ext_mode), 0);
      chk("R1 de-emphasis after reset", int'(deemph_en), 0);

      // R6 / R8: four low samples not enough, fifth enables
      for (int i = 0; i < 4; i++) frame(0, 1'b0, 0, 1'b0, "low vote");
      chk("R8 four low samples hold off", int'(deemph_en), 0);
      frame(0, 1'b0, 0, 1'b0, "low vote");
      chk("R6 fifth low sample enables", int'(deemph_en), 1);

      // R7 / R8: four highs hold, fifth disables
      for (int i = 0; i < 4; i++) frame(0, 1'b1, 0, 1'b1, "high vote");
      chk("R8 four high samples hold on", int'(deemph_en), 1);
      frame(0, 1'b1, 0, 1'b1, "high vote");
      chk("R7 fifth high sample disables", int'(deemph_en), 0);

      // R8: broken run restarts
      for (int i = 0; i < 4; i++) frame(0, 1'b0, 0, 1'b0, "broken run");
      frame(0, 1'b1, 0, 1'b0, "broken run");
      for (int i = 0; i < 4; i++) frame(0, 1'b0, 0, 1'b0, "broken run");
      chk("R8 interrupted run keeps off", int'(deemph_en), 0);
      frame(0, 1'b0, 0, 1'b0, "broken run");
      chk("R6 run of five after break", int'(deemph_en), 1);

      // R3: fifteen edges in a phase stay internal
      phase(1'b1, 15, 1'b0, "fifteen");
      chk("R3 fifteen edges stay internal", int'(ext_mode), 0);
      // R4: split bursts do not add up
      phase(1'b0, 10, 1'b0, "split a");
      phase(1'b1, 10, 1'b0, "split b");
      chk("R4 split edges stay internal", int'(ext_mode), 0);
      // R3: sixteen edges enter external mode
      phase(1'b0, 16, 1'b0, "sixteen");
      chk("R3 sixteen edges enter external", int'(ext_mode), 1);
      chk("R9 forced off in external", int'(deemph_en), 0);

      // stay external while edges keep coming
      for (int i = 0; i < 3; i++) frame(2, 1'b0, 2, 1'b0, "busy");
      chk("R5 busy frames stay external", int'(ext_mode), 1);
      // one quiet frame, then a busy one: count restarts
      frame(0, 1'b0, 0, 1'b0, "quiet one");
      frame(3, 1'b0, 0, 1'b0, "quiet reset");
      chk("R5 single quiet frame keeps external", int'(ext_mode), 1);
      frame(0, 1'b0, 0, 1'b0, "quiet");
      frame(0, 1'b0, 0, 1'b0, "quiet");
      phase(1'b1, 0, 1'b0, "quiet");
      phase(1'b0, 0, 1'b0, "quiet");
      chk("R5 two quiet frames return internal", int'(ext_mode), 0);
      // R9: history cleared, fresh run needed
      for (int i = 0; i < 3; i++) frame(0, 1'b0, 0, 1'b0, "fresh");
      chk("R9 vote restarts after return", int'(deemph_en), 0);
      for (int i = 0; i < 3; i++) frame(0, 1'b0, 0, 1'b0, "fresh");
      chk("R9 fresh run of low samples enables", int'(deemph_en), 1);

      // seeded random phases
      begin
         bit lr = 1'b1;
         bit endl = 1'b0;
         for (int k = 0; k < 170; k++) begin
            int sel = $urandom_range(0, 9);
            int n;
            case (sel)
               0, 1, 2, 3: n = 0;
               4, 5:       n = $urandom_range(1, 6);
               6:          n = 15;
               7:          n = 16;
               8:          n = 20;
               default:    n = $urandom_range(10, 17);
            endcase
            if ($urandom_range(0, 3) == 0) endl = !endl;
            phase(lr, n, endl, "random");
            lr = !lr;
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule